// File: doc/BRIEF.md
# Legacy Interrupt Virtual Wire Tracker

This block sits on the inbound header path of a serial I/O port and watches every decoded header. It picks out the messages that emulate the four legacy level-sensitive interrupt pins, lines A to D. For each line it keeps a level that an Assert message raises and a Deassert message lowers. The four levels and their OR are driven out to the interrupt logic.

Each line is a two-state machine. `WIRE_LOW` is the reset state and also means "the last action on this line was a deassert". `WIRE_HIGH` means "the last action was an assert". The four transitions are:
- `RAISE`: an assert in `WIRE_LOW` moves the line to `WIRE_HIGH`.
- `LOWER`: a deassert in `WIRE_HIGH` moves the line to `WIRE_LOW`.
- `REPEAT_HIGH`: an assert in `WIRE_HIGH` keeps the state and reports a duplicate assert.
- `REPEAT_LOW`: a deassert in `WIRE_LOW` keeps the state and reports a duplicate deassert. This includes a deassert that comes before any assert.

Duplicates are collected in a sticky 8-bit register. Software clears it by writing ones to the clear port.

Top module: `intx_wire_tracker`

## Requirements
- R1: While reset is active, and after it, before any message arrives, `line_level`, `irq_any` and `dup_status` are all zero.
- R2: A header with `hdr_valid`=1, `hdr_fmt_type`=7'b0110100 and `hdr_msg_code` 0x20, 0x21, 0x22 or 0x23 sets `line_level` bit 0, 1, 2 or 3 (lines A to D) at the next clock edge, if that line was low.
- R3: Such a header with code 0x24, 0x25, 0x26 or 0x27 clears `line_level` bit 0, 1, 2 or 3 at the next clock edge, if that line was high.
- R4: An assert for a line that is already high sets `dup_status` bit 0 to 3 (lines A to D) and leaves that line's level high.
- R5: A deassert for a line that is already low sets `dup_status` bit 4 to 7 (lines A to D) and leaves that line's level low. A line counts as low from reset onward, so a deassert with no earlier assert is a duplicate.
- R6: A header with `hdr_fmt_type`=7'b0110100 and any code outside 0x20 to 0x27, and a header with another 0110xxx type carrying any code (for example 0x18, 0x1B, 0x30, 0x31, 0x33), changes neither `line_level` nor `dup_status`.
- R7: A header whose type is not a message (for example 0000000, 1000000, 0001010) is ignored, even if its code field holds 0x20 to 0x27.
- R8: When `hdr_valid` is low, the type and code inputs have no effect.
- R9: A `dup_status` bit stays set until a 1 is written to the same bit of `dup_clr`. The bit then reads zero after the next clock edge. Zero bits of `dup_clr` have no effect.
- R10: If a clear and a new duplicate hit the same `dup_status` bit in the same cycle, the bit is set after the edge.
- R11: `irq_any` is high in exactly the cycles in which at least one bit of `line_level` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| hdr_valid | input | 1 | Single-cycle strobe marking a header on the inputs |
| hdr_fmt_type | input | 7 | Combined format/type field of the header |
| hdr_msg_code | input | 8 | Message code field of the header |
| dup_clr | input | 8 | Write-1-to-clear mask for `dup_status` |
| line_level | output | 4 | Current level of virtual lines A (bit 0) to D (bit 3) |
| irq_any | output | 1 | OR of the four line levels |
| dup_status | output | 8 | Sticky duplicate flags: bits 3:0 repeated assert, bits 7:4 repeated deassert |

## Verification
The bench builds the block with its default of four lines, which gives the full eight-bit duplicate register. Every code from 0x20 to 0x27 therefore reaches both the `RAISE`/`LOWER` transitions and the `REPEAT_HIGH`/`REPEAT_LOW` transitions of a real line machine. A reference model updates its own line levels and flag word each cycle and is compared with all three outputs on every clock. Long random phases mix message and non-message types, neighbouring codes and clear masks, so that clears landing on a bit that is being set in the same cycle also occur.

// File: rtl/intx_pkg.sv
package intx_pkg;

    localparam logic [6:0] MSG_INTX_TYPE = 7'b0110100;
    localparam logic [7:0] CODE_ASSERT_BASE = 8'h20;

    typedef enum logic {
        WIRE_LOW  = 1'b0,
        WIRE_HIGH = 1'b1
    } wire_state_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_RAISE,
        ACT_LOWER,
        ACT_REPEAT
    } wire_act_e;

endpackage

// File: rtl/intx_hdr_decode.sv
module intx_hdr_decode
    import intx_pkg::*;
#(
    parameter int LINES = 4
) (
    input  logic             hdr_valid,
    input  logic [6:0]       hdr_fmt_type,
    input  logic [7:0]       hdr_msg_code,
    output logic [LINES-1:0] asrt_hit,
    output logic [LINES-1:0] deas_hit
);

    localparam logic [7:0] CODE_DEASSERT_BASE = CODE_ASSERT_BASE + 8'(LINES);

    logic is_intx;

    always_comb begin
        is_intx = hdr_valid && (hdr_fmt_type == MSG_INTX_TYPE);
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line_dec
        always_comb begin
            asrt_hit[g] = is_intx && (hdr_msg_code == CODE_ASSERT_BASE + 8'(g));
            deas_hit[g] = is_intx && (hdr_msg_code == CODE_DEASSERT_BASE + 8'(g));
        end
    end

    always_comb begin
        if (hdr_valid) begin
            assert ($countones({asrt_hit, deas_hit}) <= 1)
                else $error("p_one_hit_r2: header decoded to more than one line action");
        end
    end

endmodule

// File: rtl/intx_line_fsm.sv
module intx_line_fsm
    import intx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic asrt_hit,
    input  logic deas_hit,
    output logic level,
    output logic dup_asrt,
    output logic dup_deas
);

    wire_state_e state_q;
    wire_state_e state_d;
    wire_act_e   act;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WIRE_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        act     = ACT_NONE;
        unique case (state_q)
            WIRE_LOW: begin
                if (asrt_hit) begin
                    state_d = WIRE_HIGH;
                    act     = ACT_RAISE;
                end else if (deas_hit) begin
                    act     = ACT_REPEAT;
                end
            end
            WIRE_HIGH: begin
                if (deas_hit) begin
                    state_d = WIRE_LOW;
                    act     = ACT_LOWER;
                end else if (asrt_hit) begin
                    act     = ACT_REPEAT;
                end
            end
            default: begin
                state_d = WIRE_LOW;
            end
        endcase
    end

    always_comb begin
        level    = (state_q == WIRE_HIGH);
        dup_asrt = (act == ACT_REPEAT) && (state_q == WIRE_HIGH);
        dup_deas = (act == ACT_REPEAT) && (state_q == WIRE_LOW);
    end

    p_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        asrt_hit |=> level)
        else $error("p_raise_r2 failed");

    p_lower_r3: assert property (@(posedge clk) disable iff (!rst_n)
        deas_hit |=> !level)
        else $error("p_lower_r3 failed");

    p_repeat_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dup_asrt |=> (level && $past(level)))
        else $error("p_repeat_high_r4 failed");

    p_repeat_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dup_deas |=> (!level && !$past(level)))
        else $error("p_repeat_low_r5 failed");

    p_quiet_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!asrt_hit && !deas_hit) |=> $stable(level))
        else $error("p_quiet_hold_r8 failed");

endmodule

// File: rtl/intx_dup_status.sv
module intx_dup_status #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] dup_set,
    input  logic [WIDTH-1:0] dup_clr,
    output logic [WIDTH-1:0] status
);

    logic [WIDTH-1:0] status_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~dup_clr) | dup_set;
        end
    end

    always_comb begin
        status = status_q;
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_chk
        p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (status_q[g] && !dup_clr[g]) |=> status_q[g])
            else $error("p_sticky_r9 failed");

        p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (dup_clr[g] && !dup_set[g]) |=> !status_q[g])
            else $error("p_clear_r9 failed");

        p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            dup_set[g] |=> status_q[g])
            else $error("p_set_wins_r10 failed");
    end

endmodule

// File: rtl/intx_wire_tracker.sv
module intx_wire_tracker
    import intx_pkg::*;
#(
    parameter int LINES = 4,
    localparam int DUP_W = 2 * LINES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hdr_valid,
    input  logic [6:0]       hdr_fmt_type,
    input  logic [7:0]       hdr_msg_code,
    input  logic [DUP_W-1:0] dup_clr,
    output logic [LINES-1:0] line_level,
    output logic             irq_any,
    output logic [DUP_W-1:0] dup_status
);

    logic [LINES-1:0] asrt_hit;
    logic [LINES-1:0] deas_hit;
    logic [LINES-1:0] dup_asrt;
    logic [LINES-1:0] dup_deas;

    intx_hdr_decode #(.LINES(LINES)) u_decode (
        .hdr_valid    (hdr_valid),
        .hdr_fmt_type (hdr_fmt_type),
        .hdr_msg_code (hdr_msg_code),
        .asrt_hit     (asrt_hit),
        .deas_hit     (deas_hit)
    );

    for (genvar g = 0; g < LINES; g++) begin : g_wire
        intx_line_fsm u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .asrt_hit (asrt_hit[g]),
            .deas_hit (deas_hit[g]),
            .level    (line_level[g]),
            .dup_asrt (dup_asrt[g]),
            .dup_deas (dup_deas[g])
        );
    end

    intx_dup_status #(.WIDTH(DUP_W)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .dup_set ({dup_deas, dup_asrt}),
        .dup_clr (dup_clr),
        .status  (dup_status)
    );

    always_comb begin
        irq_any = |line_level;
    end

    p_nonmsg_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_fmt_type != MSG_INTX_TYPE) |=> $stable(line_level))
        else $error("p_nonmsg_ignored_r7 failed");

    p_idle_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hdr_valid && dup_clr == '0) |=> ($stable(line_level) && $stable(dup_status)))
        else $error("p_idle_ignored_r8 failed");

endmodule

// File: tb/intx_wire_tracker_bench.sv
module intx_wire_tracker_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hdr_valid = 1'b0;
    logic [6:0] hdr_fmt_type = '0;
    logic [7:0] hdr_msg_code = '0;
    logic [7:0] dup_clr = '0;
    logic [3:0] line_level;
    logic       irq_any;
    logic [7:0] dup_status;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    bit         m_level [4];
    logic [7:0] m_dup;
    string      cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    intx_wire_tracker u_intx_wire_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .hdr_valid    (hdr_valid),
        .hdr_fmt_type (hdr_fmt_type),
        .hdr_msg_code (hdr_msg_code),
        .dup_clr      (dup_clr),
        .line_level   (line_level),
        .irq_any      (irq_any),
        .dup_status   (dup_status)
    );

    function automatic logic [3:0] exp_levels();
        logic [3:0] v;
        for (int i = 0; i < 4; i++) v[i] = m_level[i];
        return v;
    endfunction

    task automatic compare();
        logic [3:0] el;
        el = exp_levels();
        vectors++;
        if (line_level !== el) begin
            miscompares++;
            $display("FAIL %s line_level actual=%b expected=%b", cur_req, line_level, el);
        end
        if (dup_status !== m_dup) begin
            miscompares++;
            $display("FAIL %s dup_status actual=%b expected=%b", cur_req, dup_status, m_dup);
        end
        // R11: combined output follows the levels
        if (irq_any !== (|el)) begin
            miscompares++;
            $display("FAIL R11 irq_any actual=%b expected=%b", irq_any, |el);
        end
    endtask

    // Drive one cycle at the falling edge, update model, check at the next falling edge.
    task automatic step(input bit v, input logic [6:0] ft, input logic [7:0] code,
                        input logic [7:0] clr);
        logic [7:0] setb;
        int ln;
        hdr_valid = v; hdr_fmt_type = ft; hdr_msg_code = code; dup_clr = clr;
        setb = '0;
        if (!v) cur_req = "R8";
        else if (ft != 7'b0110100) cur_req = "R7";
        else if (code < 8'h20 || code > 8'h27) cur_req = "R6";
        else begin
            ln = int'(code[1:0]);
            if (!code[2]) begin
                if (m_level[ln]) begin setb[ln] = 1'b1; cur_req = "R4"; end
                else begin m_level[ln] = 1'b1; cur_req = "R2"; end
            end else begin
                if (!m_level[ln]) begin setb[ln+4] = 1'b1; cur_req = "R5"; end
                else begin m_level[ln] = 1'b0; cur_req = "R3"; end
            end
        end
        if ((setb & clr) != 0) cur_req = "R10";
        else if (clr != 0 && setb == 0 && cur_req != "R2" && cur_req != "R3") cur_req = "R9";
        m_dup = (m_dup & ~clr) | setb;
        @(negedge clk);
        compare();
    endtask

    task automatic intx(input logic [7:0] code);
        step(1'b1, 7'b0110100, code, 8'h00);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) m_level[i] = 1'b0;
        m_dup = '0;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        compare();
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        compare();

        // R5: deassert before any assert is a duplicate
        intx(8'h24);
        // R2: raise each line
        for (int i = 0; i < 4; i++) intx(8'h20 + 8'(i));
        // R4: repeated assert on each line
        for (int i = 0; i < 4; i++) intx(8'h20 + 8'(i));
        // R6: other messages under the message prefix
        intx(8'h18); intx(8'h1B); intx(8'h30); intx(8'h31); intx(8'h33); intx(8'h28);
        step(1'b1, 7'b0110000, 8'h24, 8'h00);
        step(1'b1, 7'b0110101, 8'h25, 8'h00);
        // R7: non-message headers carrying INTx-like codes
        step(1'b1, 7'b0000000, 8'h24, 8'h00);
        step(1'b1, 7'b1000000, 8'h25, 8'h00);
        step(1'b1, 7'b0001010, 8'h26, 8'h00);
        // R8: strobe low
        step(1'b0, 7'b0110100, 8'h27, 8'h00);
        // R3: lower each line
        for (int i = 0; i < 4; i++) intx(8'h24 + 8'(i));
        // R5: repeated deasserts
        for (int i = 0; i < 4; i++) intx(8'h24 + 8'(i));
        // R9: partial clear, zero bits untouched
        step(1'b0, 7'h00, 8'h00, 8'h0F);
        step(1'b0, 7'h00, 8'h00, 8'hF0);
        // R10: clear and new duplicate on same bit
        intx(8'h25);
        step(1'b1, 7'b0110100, 8'h25, 8'h20);

        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [6:0] ft;
            logic [7:0] code;
            logic [7:0] clr;
            r = $urandom_range(0, 9);
            ft = (r < 7) ? 7'b0110100 : ((r == 7) ? 7'b0110000 : 7'($urandom));
            code = ($urandom_range(0, 5) != 0) ? (8'h20 + 8'($urandom_range(0, 7)))
                                                : 8'($urandom);
            clr = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
            step($urandom_range(0, 4) != 0, ft, code, clr);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule